// File: doc/BRIEF.md
# Boot Configuration Decision Sequencer

After reset this block fetches nine 32-bit configuration words, one at a time and in rising address order, through a simple read port: it raises a request with an address and holds both until the memory answers with a valid strobe. Once the last word is in, it makes the boot decision in a single cycle. Control goes to the serial boot loader if the stored vector-table address is illegal, or if a backdoor is armed and the chosen input pin sits at its active level. Otherwise the flash image is started.

In the same cycle the block loads its enable, lock and boundary outputs and pulses `done` for one clock. Every enable is a full byte that counts only when it equals 0xC5. The CPU lock bits and the SRAM parity bit are stored inverted. The two security boundary pairs are loaded only when a partition control byte is *not* 0xC5. Until the pulse, every output holds a safe value: boot loader selected, access disabled, nothing locked, boundaries zero.

Word map, as byte offsets from `BASE_ADDR`:

| Offset | Word |
|---|---|
| 0x00 | boot word |
| 0x04 | vector address |
| 0x08 | access word |
| 0x0C | erase word |
| 0x10 | security option word |
| 0x14 | flash boundary word |
| 0x18 | SRAM boundary word |
| 0x1C | SRAM config word |
| 0x20 | lock word |

Top module: `boot_cfg_sequencer`

## Requirements
- R1: The k-th read (k = 0..8) presents `rd_addr` = `BASE_ADDR` + 4k with `rd_req` high. It holds that address until `rd_valid` is seen, and captures `rd_data` on the edge where `rd_req` and `rd_valid` are both high.
- R2: From reset until `done` rises, the outputs hold these values: `boot_to_loader`=1; `dbg_en`, `erase_go`, `parity_en`, `cpu_lock` and all boundary outputs = 0.
- R3: `done` is high for exactly one cycle, one clock after the ninth word is captured. No read is requested after that, and the outputs keep their values until the next reset.
- R4: A byte enables its function only when it equals 0xC5. In the access word, byte [23:16] drives `dbg_en[2]`, byte [15:8] drives `dbg_en[1]` and byte [7:0] drives `dbg_en[0]`.
- R5: The vector address is legal when bits [1:0] are 0, it lies within `FLASH_LO`..`FLASH_HI` inclusive, and it is not 0xFFFFFFFF. An illegal address sets `boot_to_loader`=1.
- R6: In the boot word, byte [31:24] is the loader enable, byte [7:0] is the backdoor enable, [15:8] is the pin number and bit 16 is the active level (1 = high, 0 = low). Entry is forced (`boot_to_loader`=1) only when both bytes are 0xC5 and `bl_pins[pin]`, sampled at the decision edge, equals the level.
- R7: A pin number at or above `PIN_CNT` never forces entry.
- R8: `cpu_lock[4:0]` is the bitwise inverse of lock word bits [4:0].
- R9: `parity_en` is the inverse of SRAM config word bit 0.
- R10: When the security option byte [15:8] is not 0xC5, the boundary outputs are loaded as follows: `flash_ns_bnd` from flash word [16:10], `flash_nsc_bnd` from flash word [9:0], `sram_ns_bnd` from SRAM word [17:9] and `sram_nsc_bnd` from SRAM word [8:0]. When that byte equals 0xC5 they stay 0.
- R11: `erase_go` = `erase_req` AND erase word bit 8, sampled at the decision edge. With bit 8 clear, a pending request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 32 | Read data |
| bl_pins | input | PIN_CNT | Candidate backdoor pins |
| erase_req | input | 1 | Pending chip-erase request |
| done | output | 1 | One-cycle decision pulse |
| boot_to_loader | output | 1 | 1 = serial boot loader, 0 = flash image |
| dbg_en | output | 3 | Debug and test access enables |
| erase_go | output | 1 | Chip erase permitted and requested |
| parity_en | output | 1 | SRAM parity enable |
| cpu_lock | output | 5 | CPU lock controls |
| flash_ns_bnd | output | 7 | Flash non-secure boundary |
| flash_nsc_bnd | output | 10 | Flash non-secure-callable boundary |
| sram_ns_bnd | output | 9 | SRAM non-secure boundary |
| sram_nsc_bnd | output | 9 | SRAM non-secure-callable boundary |

## Verification
The bench runs the sequence under several read latencies and tracks the address of each read. A design that skipped a word, reordered the reads or advanced without a valid strobe would therefore feed data to the wrong field and be caught.

The bytes 0xC4 and 0xC5 are set side by side. A decoder that tested a single bit or a nibble would enable on the wrong value.

The backdoor is exercised in these cases:
- a matching pin, active high and active low;
- a non-matching pin;
- only one of the two magic bytes set;
- a pin number beyond the pin range, which a design without the range check would index out of range.

Vector addresses are tried at the top edge of the window, one word above it, misaligned, and all-ones; an off-by-one compare would flip the boot target. The inverted and gated loads are checked both ways, so a missing inversion or a reversed boundary gate shows directly at the outputs.

// File: rtl/boot_cfg_sequencer.sv
module boot_cfg_sequencer #(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100,
  parameter logic [31:0]     FLASH_LO  = 32'h0000_0000,
  parameter logic [31:0]     FLASH_HI  = 32'h000F_FFFC,
  parameter int              PIN_CNT   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_valid,
  input  logic [31:0]        rd_data,
  input  logic [PIN_CNT-1:0] bl_pins,
  input  logic               erase_req,
  output logic               done,
  output logic               boot_to_loader,
  output logic [2:0]         dbg_en,
  output logic               erase_go,
  output logic               parity_en,
  output logic [4:0]         cpu_lock,
  output logic [6:0]         flash_ns_bnd,
  output logic [9:0]         flash_nsc_bnd,
  output logic [8:0]         sram_ns_bnd,
  output logic [8:0]         sram_nsc_bnd
);
  localparam int NWORDS = 9;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int PIN_W  = (PIN_CNT > 1) ? $clog2(PIN_CNT) : 1;
  localparam logic [7:0] MAGIC = 8'hC5;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  typedef enum logic [1:0] {S_READ, S_DECIDE, S_HOLD} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      cfg [NWORDS];

  assign rd_req  = (state == S_READ);
  assign rd_addr = BASE_ADDR + ADDR_W'({idx, 2'b00});

  logic [31:0] boot_w, vec_w, acc_w, ers_w, sec_w, fbd_w, sbd_w, scf_w, lck_w;
  assign boot_w = cfg[0];
  assign vec_w  = cfg[1];
  assign acc_w  = cfg[2];
  assign ers_w  = cfg[3];
  assign sec_w  = cfg[4];
  assign fbd_w  = cfg[5];
  assign sbd_w  = cfg[6];
  assign scf_w  = cfg[7];
  assign lck_w  = cfg[8];

  logic vec_ok, pin_ok, pin_lvl, force_bl, gate_open;
  logic [7:0] pin_num;
  assign vec_ok   = (vec_w[1:0] == 2'b00) && (vec_w >= FLASH_LO) &&
                    (vec_w <= FLASH_HI) && (vec_w != 32'hFFFF_FFFF);
  assign pin_num  = boot_w[15:8];
  assign pin_ok   = ({24'd0, pin_num} < PIN_CNT);
  assign pin_lvl  = bl_pins[pin_num[PIN_W-1:0]];
  assign force_bl = (boot_w[31:24] == MAGIC) && (boot_w[7:0] == MAGIC) &&
                    pin_ok && (pin_lvl == boot_w[16]);
  assign gate_open = (sec_w[15:8] != MAGIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_READ;
      idx   <= '0;
      for (int i = 0; i < NWORDS; i++) cfg[i] <= '0;
    end else begin
      case (state)
        S_READ: if (rd_valid) begin
          cfg[idx] <= rd_data;
          if (idx == LAST) state <= S_DECIDE;
          else idx <= idx + 1'b1;
        end
        S_DECIDE: state <= S_HOLD;
        default:  state <= S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done           <= 1'b0;
      boot_to_loader <= 1'b1;
      dbg_en         <= '0;
      erase_go       <= 1'b0;
      parity_en      <= 1'b0;
      cpu_lock       <= '0;
      flash_ns_bnd   <= '0;
      flash_nsc_bnd  <= '0;
      sram_ns_bnd    <= '0;
      sram_nsc_bnd   <= '0;
    end else begin
      done <= (state == S_DECIDE);
      if (state == S_DECIDE) begin
        boot_to_loader <= !vec_ok || force_bl;
        dbg_en    <= {acc_w[23:16] == MAGIC, acc_w[15:8] == MAGIC, acc_w[7:0] == MAGIC};
        erase_go  <= erase_req && ers_w[8];
        parity_en <= ~scf_w[0];
        cpu_lock  <= ~lck_w[4:0];
        if (gate_open) begin
          flash_ns_bnd  <= fbd_w[16:10];
          flash_nsc_bnd <= fbd_w[9:0];
          sram_ns_bnd   <= sbd_w[17:9];
          sram_nsc_bnd  <= sbd_w[8:0];
        end
      end
    end
  end

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_safe_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_HOLD && !done) |-> (boot_to_loader && dbg_en == 3'b000 &&
     cpu_lock == 5'd0 && !erase_go && !parity_en));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_read_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gate_open) |-> (flash_ns_bnd == 7'd0 && flash_nsc_bnd == 10'd0 &&
     sram_ns_bnd == 9'd0 && sram_nsc_bnd == 9'd0));

  assert_erase_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> ers_w[8]);
endmodule

// File: tb/boot_cfg_sequencer_bench.sv
`timescale 1ns/1ps
module boot_cfg_sequencer_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        rd_req, rd_valid, erase_req, done, boot_to_loader, erase_go, parity_en;
  logic [11:0] rd_addr;
  logic [31:0] rd_data;
  logic [31:0] bl_pins;
  logic [2:0]  dbg_en;
  logic [4:0]  cpu_lock;
  logic [6:0]  flash_ns_bnd;
  logic [9:0]  flash_nsc_bnd;
  logic [8:0]  sram_ns_bnd, sram_nsc_bnd;

  boot_cfg_sequencer u_boot_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .bl_pins(bl_pins),
    .erase_req(erase_req), .done(done), .boot_to_loader(boot_to_loader),
    .dbg_en(dbg_en), .erase_go(erase_go), .parity_en(parity_en),
    .cpu_lock(cpu_lock), .flash_ns_bnd(flash_ns_bnd),
    .flash_nsc_bnd(flash_nsc_bnd), .sram_ns_bnd(sram_ns_bnd),
    .sram_nsc_bnd(sram_nsc_bnd));

  int checks = 0, errors = 0;
  logic [31:0] mem [9];
  int lat = 0, cnt = 0, rcount = 0, addr_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 0; rd_data <= '0; cnt <= 0; rcount <= 0;
    end else if (rd_valid) begin
      rd_valid <= 0;
    end else if (rd_req) begin
      if (cnt >= lat) begin
        rd_valid <= 1;
        rd_data  <= (rcount < 9) ? mem[rcount] : 32'h0;
        if (rd_addr != 12'h100 + 12'(rcount * 4)) addr_err <= addr_err + 1;
        rcount <= rcount + 1;
        cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill_default();
    for (int i = 0; i < 9; i++) mem[i] = 32'hFFFF_FFFF;
    bl_pins = '0; erase_req = 1;
  endtask

  task automatic run(int l);
    lat = l; addr_err = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) break;
    end
    chk("R3 done seen", done, 1);
  endtask

  task automatic t_reset_defaults();
    fill_default();
    lat = 3; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R2 loader default", boot_to_loader, 1);
    chk("R2 dbg default", dbg_en, 0);
    chk("R2 lock default", cpu_lock, 0);
    chk("R2 bounds default", {flash_ns_bnd, flash_nsc_bnd, sram_ns_bnd, sram_nsc_bnd}, 0);
    chk("R2 erase/parity default", {erase_go, parity_en}, 0);
    chk("R1 request active", rd_req, 1);
  endtask

  task automatic t_all_ones();
    fill_default();
    run(2);
    chk("R1 read count", rcount, 9);
    chk("R1 address order", addr_err, 0);
    chk("R5 all-ones vector -> loader", boot_to_loader, 1);
    chk("R4 dbg FF disabled", dbg_en, 0);
    chk("R11 erase allowed", erase_go, 1);
    chk("R8 lock inverted", cpu_lock, 5'h00);
    chk("R9 parity inverted", parity_en, 0);
    chk("R10 flash ns", flash_ns_bnd, 7'h7F);
    chk("R10 flash nsc", flash_nsc_bnd, 10'h3FF);
    chk("R10 sram ns/nsc", {sram_ns_bnd, sram_nsc_bnd}, {9'h1FF, 9'h1FF});
    @(negedge clk);
    chk("R3 done one cycle", done, 0);
    chk("R3 no read after", rd_req, 0);
    repeat (3) @(negedge clk);
    chk("R3 outputs hold", {boot_to_loader, erase_go, cpu_lock}, {1'b1, 1'b1, 5'h00});
  endtask

  task automatic t_image_boot();
    fill_default();
    mem[0] = {8'hC5, 7'd0, 1'b1, 8'd5, 8'hC4};
    mem[1] = 32'h0000_2000;
    mem[2] = 32'h00C5_C4C5;
    mem[3] = 32'hFFFF_FEFF;
    mem[4] = 32'h0000_C500;
    mem[5] = 32'h0001_2345;
    mem[6] = 32'h0002_ABCD;
    mem[7] = 32'h0000_0000;
    mem[8] = 32'h0000_000A;
    bl_pins = 32'h20;
    run(0);
    chk("R1 address order lat0", addr_err, 0);
    chk("R6 one magic only -> image", boot_to_loader, 0);
    chk("R4 dbg C5/C4/C5", dbg_en, 3'b101);
    chk("R11 erase ignored bit8=0", erase_go, 0);
    chk("R8 lock 01010", cpu_lock, 5'b10101);
    chk("R9 parity enabled", parity_en, 1);
    chk("R10 gate closed", {flash_ns_bnd, flash_nsc_bnd, sram_ns_bnd, sram_nsc_bnd}, 0);
  endtask

  task automatic t_bounds_loaded();
    fill_default();
    mem[1] = 32'h000F_FFFC;
    mem[4] = 32'hFFFF_C4FF;
    mem[5] = {15'd0, 7'h2A, 10'h155};
    mem[6] = {14'd0, 9'h0AB, 9'h154};
    mem[8] = 32'hFFFF_FFF0;
    erase_req = 0;
    run(1);
    chk("R5 top of window legal", boot_to_loader, 0);
    chk("R10 flash loaded", {flash_ns_bnd, flash_nsc_bnd}, {7'h2A, 10'h155});
    chk("R10 sram loaded", {sram_ns_bnd, sram_nsc_bnd}, {9'h0AB, 9'h154});
    chk("R8 lock low nibble", cpu_lock, 5'b01111);
    chk("R11 no request", erase_go, 0);
  endtask

  task automatic t_vector_edges();
    fill_default();
    mem[1] = 32'h0010_0000;
    run(0);
    chk("R5 above window", boot_to_loader, 1);
    mem[1] = 32'h0000_1002;
    run(1);
    chk("R5 misaligned", boot_to_loader, 1);
  endtask

  task automatic t_backdoor();
    fill_default();
    mem[1] = 32'h0000_0400;
    mem[0] = {8'hC5, 7'd0, 1'b1, 8'd5, 8'hC5};
    bl_pins = 32'h0000_0020;
    run(1);
    chk("R6 active high match", boot_to_loader, 1);
    bl_pins = 32'hFFFF_FFDF;
    run(2);
    chk("R6 active high no match", boot_to_loader, 0);
    mem[0] = {8'hC5, 7'd0, 1'b0, 8'd31, 8'hC5};
    bl_pins = 32'h7FFF_FFFF;
    run(0);
    chk("R6 active low match", boot_to_loader, 1);
    mem[0] = {8'hC4, 7'd0, 1'b0, 8'd31, 8'hC5};
    run(0);
    chk("R6 loader byte not magic", boot_to_loader, 0);
    mem[0] = {8'hC5, 7'd0, 1'b1, 8'd32, 8'hC5};
    bl_pins = 32'hFFFF_FFFF;
    run(3);
    chk("R7 pin out of range", boot_to_loader, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill_default();
    t_reset_defaults();
    t_all_ones();
    t_image_boot();
    t_bounds_loaded();
    t_vector_edges();
    t_backdoor();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule